// File: doc/BRIEF.md
# Bit-Serial Codec Command Shifter

This block sits behind a byte-wide host register port. It turns host accesses into serial command frames for two audio codecs: one output codec (playback converter) and one input codec (capture converter). A host read at one of two opening offsets selects a codec and starts a frame. Each host write to the data offset then shifts exactly one bit onto the serial line. The bit comes from the most significant bit of the written byte. A host read at the closing offset ends the frame and releases the codec select.

Output-codec commands carry 16 bits. The upper byte of such a command names the function: 0xA6 sets the left level, 0xA7 sets the right level, and 0xA3 sets mute or unmute. Input-codec frames carry 32 bits, which are four level bytes sent in this order: mic, mic, right line, left line.

The host issues the bits most significant first. The block counts the bits in each frame. When a frame closes, it flags an error if the count does not match the length expected for the selected codec.

The host side is a valid/ready request channel with back-pressure:
- A request transfers on a clock edge where `bus_valid` and `bus_ready` are both high.
- `bus_ready` is low while a serial clock pulse is in progress.
- The host must hold its request stable until the request transfers.

Top module: `codec_cmd_shifter`

## Requirements
- R1: After reset, both selects are high (inactive), `ser_clk` is low, `busy` and `frame_err` are low, and `bus_ready` is high.
- R2: A transferred read at offset 0x38 opens an output-codec frame: `sel_out_n` goes low and `sel_in_n` stays high. A transferred read at offset 0x2C opens an input-codec frame with the selects the other way round. Opening a frame while one is active switches the select to the new codec and restarts the bit count.
- R3: Each transferred write at offset 0x2C while a frame is open produces exactly one `ser_clk` pulse. The pulse carries bit 7 of the written byte, and bits 6..0 have no effect.
- R4: Bits leave in the order they were written. A 16-bit output command such as 0xA6xx, 0xA7xx or 0xA3xx, written most significant bit first, is seen at the rising edges of `ser_clk` in that same order.
- R5: A 32-bit input frame, written in the order mic, mic, right line, left line (8 bits each, MSB first), appears on the serial line in that order.
- R6: A transferred read at offset 0x28 closes the open frame. Both selects go high and `busy` falls.
- R7: Data writes made while no frame is open are ignored: no `ser_clk` pulse occurs. A close made while no frame is open leaves `frame_err` unchanged.
- R8: At each close of an open frame, `frame_err` is set if the bit count differs from 16 (output codec) or 32 (input codec), and cleared otherwise. The flag holds its value until the next such close.
- R9: For each bit, `ser_data` takes its value while `ser_clk` is low, at least `HALF_CYC` cycles before the rising edge. It then stays stable while `ser_clk` is high for `HALF_CYC` cycles.
- R10: `bus_ready` is low from the transfer of a data write until its pulse completes. A pulse is only ever driven while a select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Host request valid |
| bus_ready | output | 1 | Block can accept a request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data; only bit 7 is used |
| ser_clk | output | 1 | Serial clock to the codecs |
| ser_data | output | 1 | Serial data to the codecs |
| sel_out_n | output | 1 | Output-codec select, active low |
| sel_in_n | output | 1 | Input-codec select, active low |
| busy | output | 1 | A frame is open or a pulse is in progress |
| frame_err | output | 1 | The last closed frame had a wrong bit count |

## Verification
The hardest situation to reach is a frame that is reopened part-way through. After the reopen, the bit counter must start again from zero, the serial line must continue without a stray pulse, and the final length check must count only the bits sent after the reopen.

The stimulus reaches this situation with a dedicated scenario:
1. Open an output frame and shift five bits.
2. Reopen the same frame.
3. Send a full 16-bit command and close.

The scenario expects `frame_err` low and the last 16 captured bits to equal the command. A short frame is sent first, so the clearing of the error flag is observed as well.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_OUT  = 2'd1,
    TGT_IN   = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2
  } phase_e;

  typedef struct packed {
    logic open_out;
    logic open_in;
    logic close;
    logic shift;
    logic bit_val;
  } bus_evt_t;

  localparam logic [7:0] DEF_OPEN_OUT_OFS = 8'h38;
  localparam logic [7:0] DEF_DATA_OFS     = 8'h2C;
  localparam logic [7:0] DEF_CLOSE_OFS    = 8'h28;
endpackage

// File: rtl/ccs_decode.sv
module ccs_decode
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OPEN_OUT_OFS = ADDR_W'(DEF_OPEN_OUT_OFS),
  parameter logic [ADDR_W-1:0] DATA_OFS     = ADDR_W'(DEF_DATA_OFS),
  parameter logic [ADDR_W-1:0] CLOSE_OFS    = ADDR_W'(DEF_CLOSE_OFS)
) (
  input  logic              fire,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output bus_evt_t          evt
);
  logic rd_fire, wr_fire;

  always_comb begin
    rd_fire      = fire && !is_write;
    wr_fire      = fire && is_write;
    evt.open_out = rd_fire && (addr == OPEN_OUT_OFS);
    evt.open_in  = rd_fire && (addr == DATA_OFS);
    evt.close    = rd_fire && (addr == CLOSE_OFS);
    evt.shift    = wr_fire && (addr == DATA_OFS);
    evt.bit_val  = wdata[DATA_W-1];
  end
endmodule

// File: rtl/ccs_frame_ctrl.sv
module ccs_frame_ctrl
  import ccs_pkg::*;
#(
  parameter int OUT_BITS = 16,
  parameter int IN_BITS  = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  bus_evt_t evt,
  output logic     shift_go,
  output logic     sel_out_n,
  output logic     sel_in_n,
  output logic     frame_open,
  output logic     frame_err
);
  localparam int CNT_MAX = (OUT_BITS > IN_BITS) ? OUT_BITS : IN_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);
  localparam logic [CNT_W-1:0] OUT_LEN = CNT_W'(OUT_BITS);
  localparam logic [CNT_W-1:0] IN_LEN  = CNT_W'(IN_BITS);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(CNT_MAX + 1);

  tgt_e             tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] want_len;

  always_comb begin
    frame_open = (tgt_q != TGT_NONE);
    shift_go   = evt.shift && frame_open;
    sel_out_n  = (tgt_q != TGT_OUT);
    sel_in_n   = (tgt_q != TGT_IN);
    want_len   = (tgt_q == TGT_OUT) ? OUT_LEN : IN_LEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q     <= TGT_NONE;
      cnt_q     <= '0;
      frame_err <= 1'b0;
    end else begin
      if (evt.open_out) begin
        tgt_q <= TGT_OUT;
        cnt_q <= '0;
      end else if (evt.open_in) begin
        tgt_q <= TGT_IN;
        cnt_q <= '0;
      end else if (evt.close) begin
        if (frame_open) frame_err <= (cnt_q != want_len);
        tgt_q <= TGT_NONE;
        cnt_q <= '0;
      end else if (shift_go && (cnt_q != SAT_VAL)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccs_bit_clocker.sv
module ccs_bit_clocker
  import ccs_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic bit_in,
  output logic ser_clk,
  output logic ser_data,
  output logic idle
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF_CYC - 1);

  phase_e        ph_q;
  logic [HW-1:0] cnt_q;

  always_comb begin
    ser_clk = (ph_q == PH_HIGH);
    idle    = (ph_q == PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      ser_data <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (go) begin
          ser_data <= bit_in;
          cnt_q    <= '0;
          ph_q     <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/codec_cmd_shifter.sv
module codec_cmd_shifter
  import ccs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int OUT_BITS = 16,
  parameter int IN_BITS  = 32,
  parameter int HALF_CYC = 2,
  parameter logic [ADDR_W-1:0] OPEN_OUT_OFS = ADDR_W'(DEF_OPEN_OUT_OFS),
  parameter logic [ADDR_W-1:0] DATA_OFS     = ADDR_W'(DEF_DATA_OFS),
  parameter logic [ADDR_W-1:0] CLOSE_OFS    = ADDR_W'(DEF_CLOSE_OFS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              sel_out_n,
  output logic              sel_in_n,
  output logic              busy,
  output logic              frame_err
);
  bus_evt_t evt;
  logic     fire, shift_go, frame_open, clk_idle;

  assign bus_ready = clk_idle;
  assign fire      = bus_valid && bus_ready;
  assign busy      = frame_open || !clk_idle;

  ccs_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OPEN_OUT_OFS(OPEN_OUT_OFS), .DATA_OFS(DATA_OFS), .CLOSE_OFS(CLOSE_OFS)
  ) u_dec (
    .fire(fire), .is_write(bus_write), .addr(bus_addr), .wdata(bus_wdata), .evt(evt)
  );

  ccs_frame_ctrl #(.OUT_BITS(OUT_BITS), .IN_BITS(IN_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .evt(evt), .shift_go(shift_go),
    .sel_out_n(sel_out_n), .sel_in_n(sel_in_n),
    .frame_open(frame_open), .frame_err(frame_err)
  );

  ccs_bit_clocker #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk(clk), .rst_n(rst_n), .go(shift_go), .bit_in(evt.bit_val),
    .ser_clk(ser_clk), .ser_data(ser_data), .idle(clk_idle)
  );
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CLOSE_OFS = 8'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ser_clk,
  input logic              ser_data,
  input logic              sel_out_n,
  input logic              sel_in_n
);
  // R9: data set up before the rising edge and held while high
  a_r9_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R10: no new request accepted during a pulse
  a_r10_ready_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !bus_ready);

  // R10: a pulse only with a codec selected
  a_r10_pulse_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> (!sel_out_n || !sel_in_n));

  // R2: never both codecs selected
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_out_n && !sel_in_n));

  // R6: close releases both selects
  a_r6_close_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write && bus_addr == CLOSE_OFS)
      |=> (sel_out_n && sel_in_n));
endmodule

bind codec_cmd_shifter ccs_checker #(.ADDR_W(ADDR_W), .CLOSE_OFS(CLOSE_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .ser_clk(ser_clk),
  .ser_data(ser_data), .sel_out_n(sel_out_n), .sel_in_n(sel_in_n)
);

// File: tb/tb_codec_cmd_shifter.sv
`timescale 1ns/1ps
module tb_codec_cmd_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_ready;
  logic       bus_write = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       ser_clk, ser_data, sel_out_n, sel_in_n, busy, frame_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [63:0] cap = '0;
  int cap_n = 0;

  always #2 clk = ~clk;

  codec_cmd_shifter dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ser_clk(ser_clk), .ser_data(ser_data), .sel_out_n(sel_out_n),
    .sel_in_n(sel_in_n), .busy(busy), .frame_err(frame_err)
  );

  always @(posedge ser_clk) begin
    cap   <= {cap[62:0], ser_data};
    cap_n <= cap_n + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic drain();
    while (!bus_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_cap();
    drain();
    cap = '0; cap_n = 0;
  endtask

  task automatic send_bits(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) xfer(1'b1, 8'h2C, {w[i], 7'(i * 37 + 5)});
  endtask

  task automatic t_reset();
    check(sel_out_n && sel_in_n, "R1 selects", {sel_out_n, sel_in_n}, 2'b11);
    check(!ser_clk && !busy && !frame_err, "R1 idle outputs",
          {ser_clk, busy, frame_err}, 0);
    check(bus_ready, "R1 ready", bus_ready, 1);
  endtask

  task automatic t_out_cmd(input logic [15:0] cmd, input string tag);
    clr_cap();
    xfer(1'b0, 8'h38, 8'h00);
    check(!sel_out_n && sel_in_n, {"R2 out select ", tag}, {sel_out_n, sel_in_n}, 2'b01);
    send_bits({48'h0, cmd}, 16);
    drain();
    check(cap_n == 16, {"R3 pulse count ", tag}, cap_n, 16);
    check(cap[15:0] == cmd, {"R4 order ", tag}, cap[15:0], cmd);
    xfer(1'b0, 8'h28, 8'h00);
    check(sel_out_n && sel_in_n && !busy, {"R6 close ", tag},
          {sel_out_n, sel_in_n, busy}, 3'b110);
    check(!frame_err, {"R8 no error ", tag}, frame_err, 0);
  endtask

  task automatic t_in_frame(input logic [7:0] mic, input logic [7:0] r, input logic [7:0] l);
    logic [31:0] w;
    w = {mic, mic, r, l};
    clr_cap();
    xfer(1'b0, 8'h2C, 8'h00);
    check(sel_out_n && !sel_in_n, "R2 in select", {sel_out_n, sel_in_n}, 2'b10);
    send_bits({32'h0, w}, 32);
    drain();
    check(cap_n == 32 && cap[31:0] == w, "R5 mic,mic,right,left order", cap[31:0], w);
    xfer(1'b0, 8'h28, 8'h00);
    check(!frame_err && sel_in_n, "R8 input frame ok", {frame_err, sel_in_n}, 2'b01);
  endtask

  task automatic t_no_frame();
    clr_cap();
    xfer(1'b1, 8'h2C, 8'hFF);
    xfer(1'b1, 8'h2C, 8'h80);
    drain();
    check(cap_n == 0 && !ser_clk, "R7 writes without frame ignored", cap_n, 0);
  endtask

  task automatic t_bad_len();
    xfer(1'b0, 8'h38, 8'h00);
    send_bits(64'h5, 3);
    xfer(1'b0, 8'h28, 8'h00);
    check(frame_err, "R8 short frame flags error", frame_err, 1);
    xfer(1'b0, 8'h28, 8'h00);
    check(frame_err, "R7 close with no frame leaves error", frame_err, 1);
    xfer(1'b0, 8'h2C, 8'h00);
    send_bits(64'h1234, 16);
    xfer(1'b0, 8'h28, 8'h00);
    check(frame_err, "R8 input frame of 16 bits flags error", frame_err, 1);
  endtask

  task automatic t_reopen();
    clr_cap();
    xfer(1'b0, 8'h38, 8'h00);
    send_bits(64'h1F, 5);
    xfer(1'b0, 8'h38, 8'h00);
    send_bits(64'hA30D, 16);
    drain();
    check(cap_n == 21 && cap[15:0] == 16'hA30D, "R2 reopen restarts", cap[15:0], 16'hA30D);
    xfer(1'b0, 8'h28, 8'h00);
    check(!frame_err, "R8 reopen counts only new bits", frame_err, 0);
    xfer(1'b0, 8'h38, 8'h00);
    xfer(1'b0, 8'h2C, 8'h00);
    check(sel_out_n && !sel_in_n, "R2 switch target", {sel_out_n, sel_in_n}, 2'b10);
    xfer(1'b0, 8'h28, 8'h00);
  endtask

  task automatic t_backpressure();
    int hi;
    xfer(1'b0, 8'h38, 8'h00);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h2C; bus_wdata = 8'h80;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    check(!bus_ready && !ser_clk && ser_data, "R10 ready low, data set before rise",
          {bus_ready, ser_clk, ser_data}, 3'b001);
    while (!ser_clk) @(negedge clk);
    hi = 0;
    while (ser_clk) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 2, "R9 high width", hi, 2);
    xfer(1'b0, 8'h28, 8'h00);
    xfer(1'b1, 8'h38, 8'h80);
    xfer(1'b0, 8'h10, 8'h00);
    check(sel_out_n && sel_in_n && !busy, "R10 other accesses ignored",
          {sel_out_n, sel_in_n, busy}, 3'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_out_cmd(16'hA6C3, "left");
    t_out_cmd(16'hA755, "right");
    t_in_frame(8'h9A, 8'h3C, 8'hE1);
    t_no_frame();
    t_bad_len();
    t_reopen();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule